// File: doc/BRIEF.md
# Boot Region Lock and Erase Target Selector

This block sits beside the command decoder of a word-wide flash array. It turns each decoded request (chip erase, sector erase, word program, or lock enable) into grants for the array. For an erase, the grant is a set of per-region erase enables. For a program, it is a single program-allowed flag. The array is split into four regions: a boot region, two parameter regions and a main region. One build parameter places the boot region either at the lowest or at the highest addresses, and every region boundary and sector code follows from that choice.

A sticky lock controls the boot region. While the lock is clear, the boot region and the main region form a single erase sector, and chip erase clears everything. Once a lock-enable request sets the lock:

- Chip erase does nothing.
- A main-sector erase spares the boot region.
- Word programs aimed at the boot region are refused.

A high-voltage override input bypasses the lock for any request made while it is held. Ordinary reset leaves the lock untouched. Only the separate fresh-part input clears it. The lock is visible on `id_lock_bit` when identification mode reads address 2.

The lock is a two-state machine with states LK_OPEN and LK_SHUT. Transition SET goes from LK_OPEN to LK_SHUT on a lock-enable request. Transition FRESH returns any state to LK_OPEN when `fresh_n` is low. LK_SHUT otherwise holds.

Top module: `bootlock_sel`

## Requirements
- R1: While `rst_n` is low, `dec_valid`, `erase_en` and `prog_ok` are 0, and the lock state is not changed by `rst_n`.
- R2: Every request is answered one clock later, with `dec_valid` high for exactly that cycle. In a cycle after no request, all three decision outputs are 0.
- R3: `req_kind` is encoded as follows: 0 = chip erase, 1 = sector erase, 2 = program, 3 = lock enable. `erase_en` bit 0 is boot, bit 1 is parameter 1, bit 2 is parameter 2 and bit 3 is main. Sector codes are taken from address bits 18:12:
  - bottom variant: 03h selects parameter 1, 05h selects parameter 2, 7Fh selects main;
  - top variant: 7Dh selects parameter 1, 7Bh selects parameter 2, 79h selects main.
- R4: A main-sector erase gives `erase_en` = 1001b when the lock is clear (or overridden), and 1000b when the lock is set.
- R5: Chip erase gives 1111b when the lock is clear (or overridden), and 0000b when the lock is set.
- R6: A program request gives `prog_ok` = 1 unless both of these hold: the address lies in the boot region, and the lock is set without override. The boot region is 00000h–01FFFh (bottom variant) or 7E000h–7FFFFh (top variant).
- R7: With `hv_override` high in the request cycle, the request is decided as if the lock were clear. Once the override is low again, the lock applies again.
- R8: The lock is set by a lock-enable request while `rst_n` is high. It stays set across `rst_n`, and it is cleared only by `fresh_n` low. `lock_status` shows the lock.
- R9: `id_lock_bit` is 1 only when `id_mode` is high, `addr` = 00002h and the lock is set.
- R10: A sector erase whose code matches no sector gives `erase_en` = 0000b.
- R11: A lock-enable request gives `erase_en` = 0 and `prog_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the decision registers |
| fresh_n | input | 1 | Active-low clear of the lock, modelling a fresh part |
| req_valid | input | 1 | A decoded request is present this cycle |
| req_kind | input | 2 | Request type: 0 chip erase, 1 sector erase, 2 program, 3 lock enable |
| addr | input | 19 | Word address or sector address of the request |
| hv_override | input | 1 | High-voltage override, sampled per request |
| id_mode | input | 1 | Identification mode is active |
| dec_valid | output | 1 | Decision outputs are valid |
| erase_en | output | 4 | Per-region erase enables: bit 0 boot, 1 parameter 1, 2 parameter 2, 3 main |
| prog_ok | output | 1 | Word program is permitted |
| lock_status | output | 1 | Lock state |
| id_lock_bit | output | 1 | Lock bit as read at address 2 in identification mode |

## Verification
The hardest situations to reach are the ones that need the lock set and also need the next request to hit a boot-region address or the main sector code, with the override either held or released. Uniform random addresses almost never produce a valid sector code, and a freely drawn lock request would lock the part for the rest of the run. The stimulus therefore draws addresses from a pool weighted toward the six sector codes, the boot-region edges and address 2. It keeps lock-enable requests rare, and it pulses the fresh-part input at intervals so the run moves back and forth between locked and unlocked phases. A directed prologue visits each lock, override and reset combination once. Both variants are instantiated side by side and driven with the same stimulus.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
    localparam int REGION_N = 4;

    typedef enum logic [1:0] {
        REQ_CHIP   = 2'd0,
        REQ_SECTOR = 2'd1,
        REQ_PROG   = 2'd2,
        REQ_LOCK   = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        RG_BOOT = 2'd0,
        RG_PAR1 = 2'd1,
        RG_PAR2 = 2'd2,
        RG_MAIN = 2'd3
    } region_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_t;
endpackage

// File: rtl/bl_region_map.sv
module bl_region_map
    import bootlock_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int BLK_W    = 13,
    parameter int SEC_LSB  = 12,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           word_region,
    output logic              sec_hit,
    output region_t           sec_region
);
    localparam int TAG_W = ADDR_W - BLK_W;
    localparam int SEC_W = ADDR_W - SEC_LSB;
    localparam logic [SEC_W-1:0] ONES = {SEC_W{1'b1}};

    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] ntag;
    logic [SEC_W-1:0] code;
    logic [SEC_W-1:0] c_par1;
    logic [SEC_W-1:0] c_par2;
    logic [SEC_W-1:0] c_main;

    assign tag  = addr[ADDR_W-1:BLK_W];
    assign code = addr[ADDR_W-1:SEC_LSB];

    // The variant mirrors the block index and picks its own sector codes.
    generate
        if (TOP_BOOT) begin : g_top
            assign ntag   = ~tag;
            assign c_par1 = ONES - SEC_W'(2);
            assign c_par2 = ONES - SEC_W'(4);
            assign c_main = ONES - SEC_W'(6);
        end else begin : g_bottom
            assign ntag   = tag;
            assign c_par1 = SEC_W'(3);
            assign c_par2 = SEC_W'(5);
            assign c_main = ONES;
        end
    endgenerate

    always_comb begin
        if (ntag == TAG_W'(0))      word_region = RG_BOOT;
        else if (ntag == TAG_W'(1)) word_region = RG_PAR1;
        else if (ntag == TAG_W'(2)) word_region = RG_PAR2;
        else                        word_region = RG_MAIN;
    end

    always_comb begin
        sec_hit    = 1'b1;
        sec_region = RG_MAIN;
        if (code == c_par1)      sec_region = RG_PAR1;
        else if (code == c_par2) sec_region = RG_PAR2;
        else if (code == c_main) sec_region = RG_MAIN;
        else                     sec_hit    = 1'b0;
    end
endmodule

// File: rtl/bl_lock_fsm.sv
module bl_lock_fsm
    import bootlock_pkg::*;
(
    input  logic clk,
    input  logic fresh_n,
    input  logic set_stb,
    output logic locked
);
    lock_state_t st, st_nxt;

    // State register: only the fresh-part input returns it to LK_OPEN.
    always_ff @(posedge clk or negedge fresh_n) begin
        if (!fresh_n) st <= LK_OPEN;
        else          st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            LK_OPEN: if (set_stb) st_nxt = LK_SHUT;   // SET
            LK_SHUT: st_nxt = LK_SHUT;
        endcase
    end

    assign locked = (st == LK_SHUT);
endmodule

// File: rtl/bl_grant.sv
module bl_grant
    import bootlock_pkg::*;
(
    input  req_kind_t                kind,
    input  logic                     guard,
    input  region_t                  word_region,
    input  logic                     sec_hit,
    input  region_t                  sec_region,
    output logic [REGION_N-1:0]      erase_nxt,
    output logic                     prog_nxt
);
    always_comb begin
        erase_nxt = '0;
        prog_nxt  = 1'b0;
        unique case (kind)
            REQ_CHIP: begin
                if (!guard) erase_nxt = '1;
            end
            REQ_SECTOR: begin
                if (sec_hit) begin
                    erase_nxt[sec_region] = 1'b1;
                    if (sec_region == RG_MAIN && !guard)
                        erase_nxt[RG_BOOT] = 1'b1;
                end
            end
            REQ_PROG: begin
                prog_nxt = !(guard && word_region == RG_BOOT);
            end
            REQ_LOCK: begin
                erase_nxt = '0;
                prog_nxt  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bootlock_sel.sv
module bootlock_sel
    import bootlock_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int BLK_W    = 13,
    parameter int SEC_LSB  = 12,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fresh_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hv_override,
    input  logic              id_mode,
    output logic              dec_valid,
    output logic [3:0]        erase_en,
    output logic              prog_ok,
    output logic              lock_status,
    output logic              id_lock_bit
);
    localparam logic [ADDR_W-1:0] ID_LOCK_ADDR = ADDR_W'(2);

    req_kind_t           kind;
    region_t             word_region;
    region_t             sec_region;
    logic                sec_hit;
    logic                locked;
    logic                guard;
    logic                set_stb;
    logic [REGION_N-1:0] erase_nxt;
    logic                prog_nxt;

    assign kind    = req_kind_t'(req_kind);
    assign set_stb = rst_n && req_valid && (kind == REQ_LOCK);
    assign guard   = locked && !hv_override;

    bl_region_map #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SEC_LSB(SEC_LSB), .TOP_BOOT(TOP_BOOT)
    ) u_map (
        .addr(addr), .word_region(word_region),
        .sec_hit(sec_hit), .sec_region(sec_region)
    );

    bl_lock_fsm u_lock (
        .clk(clk), .fresh_n(fresh_n), .set_stb(set_stb), .locked(locked)
    );

    bl_grant u_grant (
        .kind(kind), .guard(guard), .word_region(word_region),
        .sec_hit(sec_hit), .sec_region(sec_region),
        .erase_nxt(erase_nxt), .prog_nxt(prog_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            erase_en  <= '0;
            prog_ok   <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            erase_en  <= req_valid ? erase_nxt : '0;
            prog_ok   <= req_valid && prog_nxt;
        end
    end

    assign lock_status = locked;
    assign id_lock_bit = id_mode && (addr == ID_LOCK_ADDR) && locked;
endmodule

// File: rtl/bl_checker.sv
module bl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fresh_n,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       hv_override,
    input logic       dec_valid,
    input logic [3:0] erase_en,
    input logic       prog_ok,
    input logic       lock_status
);
    a_r5_chip_blocked: assert property (@(posedge clk) disable iff (!rst_n || !fresh_n)
        (req_valid && req_kind == 2'd0 && lock_status && !hv_override) |=> (erase_en == 4'b0000));

    a_r4_boot_kept: assert property (@(posedge clk) disable iff (!rst_n || !fresh_n)
        (req_valid && req_kind == 2'd1 && lock_status && !hv_override) |=> !erase_en[0]);

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!fresh_n)
        lock_status |=> lock_status);

    a_r11_lock_no_grant: assert property (@(posedge clk) disable iff (!rst_n || !fresh_n)
        (req_valid && req_kind == 2'd3) |=> (erase_en == 4'b0000 && !prog_ok));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !fresh_n)
        !req_valid |=> (!dec_valid && erase_en == 4'b0000 && !prog_ok));

    a_r6_prog_alone: assert property (@(posedge clk) disable iff (!rst_n || !fresh_n)
        prog_ok |-> (erase_en == 4'b0000 && dec_valid));
endmodule

bind bootlock_sel bl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .req_valid(req_valid),
    .req_kind(req_kind), .hv_override(hv_override), .dec_valid(dec_valid),
    .erase_en(erase_en), .prog_ok(prog_ok), .lock_status(lock_status)
);

// File: tb/bootlock_sel_test.sv
`timescale 1ns/1ps
module bootlock_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, fresh_n = 1'b0;
    logic        req_valid = 1'b0, hv_override = 1'b0, id_mode = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [18:0] addr = '0;
    logic        dv0, dv1, po0, po1, ls0, ls1, id0, id1;
    logic [3:0]  er0, er1;

    always #2.5 clk = ~clk;

    bootlock_sel #(.TOP_BOOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .req_valid(req_valid),
        .req_kind(req_kind), .addr(addr), .hv_override(hv_override), .id_mode(id_mode),
        .dec_valid(dv0), .erase_en(er0), .prog_ok(po0), .lock_status(ls0), .id_lock_bit(id0));

    bootlock_sel #(.TOP_BOOT(1'b1)) uut_top (
        .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .req_valid(req_valid),
        .req_kind(req_kind), .addr(addr), .hv_override(hv_override), .id_mode(id_mode),
        .dec_valid(dv1), .erase_en(er1), .prog_ok(po1), .lock_status(ls1), .id_lock_bit(id1));

    int n_chk = 0, n_fail = 0;
    bit m_lock = 1'b0;
    bit pend = 1'b0;
    logic       p_dv;
    logic [3:0] p_e0, p_e1;
    logic       p_p0, p_p1;
    string      p_tag;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected decision for one variant, from the requirements.
    function automatic void model(bit top, logic [1:0] k, logic [18:0] a, bit eff,
                                  output logic [3:0] e, output logic p);
        logic [6:0] c;
        bit boot;
        c = a[18:12];
        boot = top ? (a[18:13] == 6'h3F) : (a[18:13] == 6'h00);
        e = 4'b0000;
        p = 1'b0;
        case (k)
            2'd0: e = eff ? 4'b0000 : 4'b1111;
            2'd1: begin
                if (c == (top ? 7'h7D : 7'h03))      e = 4'b0010;
                else if (c == (top ? 7'h7B : 7'h05)) e = 4'b0100;
                else if (c == (top ? 7'h79 : 7'h7F)) e = eff ? 4'b1000 : 4'b1001;
            end
            2'd2: p = !(boot && eff);
            default: ;
        endcase
    endfunction

    function automatic string tag_of(logic v, logic [1:0] k, logic [18:0] a, logic hv);
        if (!v) return "R2 idle";
        if (hv && m_lock) return "R7 override";
        case (k)
            2'd0: return "R5 chip";
            2'd1: return (a[18:12] == 7'h7F || a[18:12] == 7'h79) ? "R4 main sector" :
                         (a[18:12] == 7'h03 || a[18:12] == 7'h05 ||
                          a[18:12] == 7'h7D || a[18:12] == 7'h7B) ? "R3 sector" : "R10 no sector";
            2'd2: return "R6 program";
            default: return "R11 lock request";
        endcase
    endfunction

    task automatic check_pending();
        if (pend) begin
            chk({p_tag, " dec_valid"}, dv0, p_dv);
            chk({p_tag, " erase bottom"}, er0, p_e0);
            chk({p_tag, " erase top"}, er1, p_e1);
            chk({p_tag, " prog bottom"}, po0, p_p0);
            chk({p_tag, " prog top"}, po1, p_p1);
        end
    endtask

    task automatic step(logic v, logic [1:0] k, logic [18:0] a, logic hv,
                        logic idm, logic rs, logic fr);
        bit eff;
        @(negedge clk);
        check_pending();
        rst_n = rs; fresh_n = fr; req_valid = v; req_kind = k;
        addr = a; hv_override = hv; id_mode = idm;
        if (!fr) m_lock = 1'b0;
        #0.5;
        chk("R8 lock_status bottom", ls0, m_lock);
        chk("R8 lock_status top", ls1, m_lock);
        chk("R9 id bit bottom", id0, idm && a == 19'h2 && m_lock);
        chk("R9 id bit top", id1, idm && a == 19'h2 && m_lock);
        eff = m_lock && !hv;
        if (!rs || !v) begin
            p_dv = 1'b0; p_e0 = '0; p_e1 = '0; p_p0 = 1'b0; p_p1 = 1'b0;
            p_tag = !rs ? "R1 reset" : "R2 idle";
        end else begin
            p_dv = 1'b1;
            model(1'b0, k, a, eff, p_e0, p_p0);
            model(1'b1, k, a, eff, p_e1, p_p1);
            p_tag = tag_of(v, k, a, hv);
        end
        pend = 1'b1;
        if (rs && fr && v && k == 2'd3) m_lock = 1'b1;
    endtask

    function automatic logic [18:0] pick_addr();
        logic [11:0] lo;
        lo = 12'($urandom);
        case ($urandom % 9)
            0: return {7'h03, lo};
            1: return {7'h05, lo};
            2: return {7'h7F, lo};
            3: return {7'h7D, lo};
            4: return {7'h7B, lo};
            5: return {7'h79, lo};
            6: return ($urandom % 2) ? {6'h00, 13'($urandom)} : {6'h3F, 13'($urandom)};
            7: return 19'h00002;
            default: return 19'($urandom);
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (2) @(negedge clk);
        // R1: decision outputs quiet in reset
        chk("R1 reset dec_valid", dv0, 0);
        chk("R1 reset erase", er0, 0);
        chk("R1 reset prog", po1, 0);
        step(0, 2'd0, 19'h0, 0, 0, 1, 1);
        // Unlocked corner cases
        step(1, 2'd2, 19'h00010, 0, 0, 1, 1);   // R6 boot program allowed unlocked (bottom)
        step(1, 2'd2, 19'h7FFF0, 0, 0, 1, 1);   // R6 boot program allowed unlocked (top)
        step(1, 2'd1, 19'h7F000, 0, 0, 1, 1);   // R4 bottom main + boot
        step(1, 2'd1, 19'h79ABC, 0, 0, 1, 1);   // R4 top main + boot
        step(1, 2'd0, 19'h15555, 0, 0, 1, 1);   // R5 chip all
        step(1, 2'd1, 19'h04000, 0, 0, 1, 1);   // R10 unmatched code
        step(1, 2'd0, 19'h00002, 0, 1, 1, 1);   // R9 unlocked id read
        // Lock and locked behaviour
        step(1, 2'd3, 19'h15555, 0, 0, 1, 1);   // R11 lock request, R8 set
        step(1, 2'd0, 19'h15555, 0, 0, 1, 1);   // R5 chip suppressed
        step(1, 2'd1, 19'h7F123, 0, 0, 1, 1);   // R4 main only
        step(1, 2'd2, 19'h01FFF, 0, 0, 1, 1);   // R6 boot program blocked
        step(1, 2'd2, 19'h7E000, 0, 0, 1, 1);   // R6 top boot edge blocked
        step(1, 2'd2, 19'h02000, 0, 0, 1, 1);   // R6 just outside boot
        step(1, 2'd2, 19'h00100, 1, 0, 1, 1);   // R7 override allows program
        step(1, 2'd0, 19'h15555, 1, 0, 1, 1);   // R7 override allows chip erase
        step(1, 2'd2, 19'h00100, 0, 0, 1, 1);   // R7 lock back once override drops
        step(1, 2'd0, 19'h00002, 0, 1, 1, 1);   // R9 locked id read
        step(1, 2'd0, 19'h00003, 0, 1, 1, 1);   // R9 other address
        step(1, 2'd3, 19'h0, 0, 0, 0, 1);       // R1 reset: outputs zero, lock kept
        step(0, 2'd0, 19'h0, 0, 0, 1, 1);       // R8 lock survives reset
        step(1, 2'd2, 19'h00000, 0, 0, 1, 0);   // R8 fresh clears lock
        step(1, 2'd2, 19'h00000, 0, 0, 1, 1);
        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] k;
            k = 2'($urandom % 4);
            if (k == 2'd3 && ($urandom % 10) != 0) k = 2'd1;
            step(($urandom % 4) != 0, k, pick_addr(), ($urandom % 5) == 0,
                 ($urandom % 3) == 0, (i % 311) != 310, (i % 517) != 516);
        end
        @(negedge clk);
        check_pending();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule